// File: doc/BRIEF.md
# Condition Code Branch Evaluator

This block decides whether a conditional control-transfer instruction (branch, conditional move or conditional trap) is taken. It has three ways of judging. The first two test a 4-bit condition against one of two parallel flag sets, one produced by 32-bit arithmetic and one by 64-bit arithmetic. The instruction picks the flag set through a selector field. The third way compares a register operand against zero as a signed number, under a 3-bit register-condition code.

The result is registered. One cycle after a request strobe the block raises a done pulse and presents three outputs: a taken decision, an illegal-encoding flag and a floating-point-disabled flag. A selector that names a floating-point condition set does not produce a decision. It only raises the disabled flag, and the calling pipeline turns that into a fault. Target addresses and delay slots are handled elsewhere.

Top module: `cond_eval`

## Requirements
- R1: While reset is active, and after it is released until the first request, `done_o`, `taken_o`, `illegal_o` and `fp_off_o` are all 0.
- R2: `done_o` is 1 in exactly the cycle after a cycle in which `req_i` is 1, and 0 otherwise. `taken_o`, `illegal_o` and `fp_off_o` change only in that cycle and hold their values while no request arrives.
- R3: Condition code 0x0 is never taken and 0x8 is always taken, whatever the flags hold. Flags are packed as {N, Z, V, C}, bit 3 down to bit 0.
- R4: The signed codes are 0x2 (Z or N≠V), 0x3 (N≠V), 0xA (Z clear and N=V) and 0xB (N=V).
- R5: The remaining codes are 0x1 (Z), 0x4 (C or Z), 0x5 (C), 0x6 (N) and 0x7 (V). Codes 0x9 and 0xC to 0xF are the complements of 0x1 and 0x4 to 0x7 respectively.
- R6: In branch mode (`mode_i`=0), a selector `sel_i` of 0 tests `cc32_i`, 2 tests `cc64_i`, and 1 or 3 sets `illegal_o`.
- R7: In move mode (`mode_i`=1), the bank index {`bank_hi_i`, `sel_i`} selects as follows: 0 to 3 set `fp_off_o`; 4 tests `cc32_i`; 6 tests `cc64_i`; 5 and 7 set `illegal_o`.
- R8: In register mode (`mode_i`=2), the signed value `rval_i` is compared with zero. Code 1 tests ==0, 2 tests <=0, 3 tests <0, 5 tests !=0, 6 tests >0 and 7 tests >=0.
- R9: In register mode, codes 0 and 4 set `illegal_o`. `mode_i`=3 also sets `illegal_o`.
- R10: Whenever `illegal_o` or `fp_off_o` is 1, `taken_o` is 0. `illegal_o` and `fp_off_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Evaluate the presented operands this cycle |
| mode_i | input | 2 | 0 branch on flags, 1 move on flags, 2 register versus zero, 3 reserved |
| cond_i | input | 4 | Flag condition code |
| sel_i | input | 2 | Flag-set selector (low bank bits in move mode) |
| bank_hi_i | input | 1 | Upper bank bit in move mode |
| cc32_i | input | 4 | Flags from 32-bit arithmetic, {N,Z,V,C} |
| cc64_i | input | 4 | Flags from 64-bit arithmetic, {N,Z,V,C} |
| rcond_i | input | 3 | Register-condition code |
| rval_i | input | DATA_W | Register operand, signed |
| done_o | output | 1 | Result valid pulse |
| taken_o | output | 1 | Condition holds |
| illegal_o | output | 1 | Illegal encoding |
| fp_off_o | output | 1 | Floating-point condition requested |

## Verification
The bench builds the block with `DATA_W` set to 8. This makes every register operand reachable, so the sweep checks all signed boundaries of the register tests: zero, the largest positive value and the most negative value, under every code. For each of the four branch selectors and each of the eight move banks, all 16 condition codes are tried against all 16 flag patterns. The other flag set always carries the complement pattern, so a read from the wrong set shows up as a mismatch. Separate cases check that results hold between requests.

// File: rtl/cond_eval_pkg.sv
package cond_eval_pkg;

  typedef enum logic [1:0] {
    MODE_BRANCH = 2'd0,
    MODE_MOVE   = 2'd1,
    MODE_REGZ   = 2'd2,
    MODE_RSVD   = 2'd3
  } eval_mode_e;

  typedef struct packed {
    logic neg;
    logic zero;
    logic ovf;
    logic carry;
  } flags_t;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_CC32 = 2'd1,
    SRC_CC64 = 2'd2
  } flag_src_e;

endpackage

// File: rtl/cond_src_decode.sv
module cond_src_decode
  import cond_eval_pkg::*;
(
  input  eval_mode_e mode_i,
  input  logic [1:0] sel_i,
  input  logic       bank_hi_i,
  output flag_src_e  src_o,
  output logic       use_reg_o,
  output logic       illegal_o,
  output logic       fp_off_o
);

  logic [2:0] bank;

  always_comb begin
    bank      = {bank_hi_i, sel_i};
    src_o     = SRC_NONE;
    use_reg_o = 1'b0;
    illegal_o = 1'b0;
    fp_off_o  = 1'b0;
    unique case (mode_i)
      MODE_BRANCH: begin
        unique case (sel_i)
          2'd0:    src_o = SRC_CC32;
          2'd2:    src_o = SRC_CC64;
          default: illegal_o = 1'b1;
        endcase
      end
      MODE_MOVE: begin
        if (!bank[2]) begin
          fp_off_o = 1'b1;
        end else if (bank[0]) begin
          illegal_o = 1'b1;
        end else begin
          src_o = bank[1] ? SRC_CC64 : SRC_CC32;
        end
      end
      MODE_REGZ: use_reg_o = 1'b1;
      default:   illegal_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/cond_flag_test.sv
module cond_flag_test
  import cond_eval_pkg::*;
(
  input  logic [3:0] cond_i,
  input  flags_t     flags_i,
  output logic       hit_o
);

  logic base;
  logic signed_lt;

  always_comb begin
    signed_lt = flags_i.neg ^ flags_i.ovf;
    unique case (cond_i[2:0])
      3'd0: base = 1'b0;
      3'd1: base = flags_i.zero;
      3'd2: base = flags_i.zero | signed_lt;
      3'd3: base = signed_lt;
      3'd4: base = flags_i.carry | flags_i.zero;
      3'd5: base = flags_i.carry;
      3'd6: base = flags_i.neg;
      default: base = flags_i.ovf;
    endcase
    hit_o = base ^ cond_i[3];
  end

endmodule

// File: rtl/cond_reg_test.sv
module cond_reg_test #(
  parameter int DATA_W = 64
) (
  input  logic [2:0]        rcond_i,
  input  logic [DATA_W-1:0] value_i,
  output logic              hit_o,
  output logic              bad_o
);

  localparam int SIGN_BIT = DATA_W - 1;

  logic is_zero;
  logic is_neg;
  logic base;

  always_comb begin
    is_zero = (value_i == '0);
    is_neg  = value_i[SIGN_BIT];
    bad_o   = (rcond_i[1:0] == 2'd0);
    unique case (rcond_i[1:0])
      2'd1:    base = is_zero;
      2'd2:    base = is_zero | is_neg;
      2'd3:    base = is_neg;
      default: base = 1'b0;
    endcase
    hit_o = bad_o ? 1'b0 : (base ^ rcond_i[2]);
  end

endmodule

// File: rtl/cond_eval.sv
module cond_eval
  import cond_eval_pkg::*;
#(
  parameter int DATA_W   = 64,
  parameter int SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [1:0]        mode_i,
  input  logic [3:0]        cond_i,
  input  logic [1:0]        sel_i,
  input  logic              bank_hi_i,
  input  logic [3:0]        cc32_i,
  input  logic [3:0]        cc64_i,
  input  logic [2:0]        rcond_i,
  input  logic [DATA_W-1:0] rval_i,
  output logic              done_o,
  output logic              taken_o,
  output logic              illegal_o,
  output logic              fp_off_o
);

  localparam int SYNC_MSB = SYNC_LEN - 1;

  // reset release synchroniser
  logic [SYNC_MSB:0] rst_pipe_q;
  logic              rst_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[SYNC_MSB-1:0], 1'b1};
    end
  end
  assign rst_ok = rst_pipe_q[SYNC_MSB];

  eval_mode_e mode;
  flag_src_e  src;
  flags_t     sel_flags;
  logic       use_reg, dec_illegal, dec_fp;
  logic       flag_hit, reg_hit, reg_bad;
  logic       done_d, taken_d, illegal_d, fp_d;
  logic       done_q, taken_q, illegal_q, fp_q;

  assign mode = eval_mode_e'(mode_i);

  cond_src_decode u_decode (
    .mode_i    (mode),
    .sel_i     (sel_i),
    .bank_hi_i (bank_hi_i),
    .src_o     (src),
    .use_reg_o (use_reg),
    .illegal_o (dec_illegal),
    .fp_off_o  (dec_fp)
  );

  always_comb begin
    unique case (src)
      SRC_CC32: sel_flags = flags_t'(cc32_i);
      SRC_CC64: sel_flags = flags_t'(cc64_i);
      default:  sel_flags = '0;
    endcase
  end

  cond_flag_test u_flag (
    .cond_i  (cond_i),
    .flags_i (sel_flags),
    .hit_o   (flag_hit)
  );

  cond_reg_test #(.DATA_W(DATA_W)) u_reg (
    .rcond_i (rcond_i),
    .value_i (rval_i),
    .hit_o   (reg_hit),
    .bad_o   (reg_bad)
  );

  // next state
  always_comb begin
    done_d    = req_i;
    illegal_d = illegal_q;
    fp_d      = fp_q;
    taken_d   = taken_q;
    if (req_i) begin
      illegal_d = dec_illegal | (use_reg & reg_bad);
      fp_d      = dec_fp;
      if (illegal_d || fp_d) begin
        taken_d = 1'b0;
      end else begin
        taken_d = use_reg ? reg_hit : flag_hit;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      done_q    <= 1'b0;
      taken_q   <= 1'b0;
      illegal_q <= 1'b0;
      fp_q      <= 1'b0;
    end else begin
      done_q <= done_d;
      if (req_i) begin
        taken_q   <= taken_d;
        illegal_q <= illegal_d;
        fp_q      <= fp_d;
      end
    end
  end

  assign done_o    = done_q;
  assign taken_o   = taken_q;
  assign illegal_o = illegal_q;
  assign fp_off_o  = fp_q;

  AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_ok)
    req_i |=> done_o); // R2
  AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_ok)
    !req_i |=> !done_o); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_ok)
    !req_i |=> ($stable(taken_o) && $stable(illegal_o) && $stable(fp_off_o))); // R2
  AST_ALWAYS_CODE: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_i && mode_i == 2'd0 && sel_i == 2'd0 && cond_i == 4'h8) |=> taken_o); // R3
  AST_ODD_SEL_BAD: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_i && mode_i == 2'd0 && sel_i[0]) |=> illegal_o); // R6
  AST_FP_BANK: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_i && mode_i == 2'd1 && !bank_hi_i) |=> fp_off_o); // R7
  AST_REG_ZERO_EQ: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_i && mode_i == 2'd2 && rcond_i == 3'd1 && rval_i == '0) |=> taken_o); // R8
  AST_REG_CODE_BAD: assert property (@(posedge clk) disable iff (!rst_ok)
    (req_i && mode_i == 2'd2 && rcond_i[1:0] == 2'd0) |=> illegal_o); // R9
  AST_BAD_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_ok)
    (illegal_o || fp_off_o) |-> !taken_o); // R10
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_ok)
    !(illegal_o && fp_off_o)); // R10

endmodule

// File: tb/test_cond_eval.sv
module test_cond_eval;

  localparam int CLK_PERIOD = 10;
  localparam int DW         = 8;
  localparam int WATCHDOG   = 150000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic [1:0]    mode = '0;
  logic [3:0]    cond = '0;
  logic [1:0]    sel = '0;
  logic          bank_hi = 1'b0;
  logic [3:0]    cc32 = '0;
  logic [3:0]    cc64 = '0;
  logic [2:0]    rcond = '0;
  logic [DW-1:0] rval = '0;
  logic          done, taken, illegal, fp_off;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cond_eval #(.DATA_W(DW)) i_cond_eval (
    .clk(clk), .rst_n(rst_n), .req_i(req), .mode_i(mode), .cond_i(cond),
    .sel_i(sel), .bank_hi_i(bank_hi), .cc32_i(cc32), .cc64_i(cc64),
    .rcond_i(rcond), .rval_i(rval), .done_o(done), .taken_o(taken),
    .illegal_o(illegal), .fp_off_o(fp_off)
  );

  function automatic bit flag_expect(int c, logic [3:0] f);
    bit n, z, v, cy;
    n = f[3]; z = f[2]; v = f[1]; cy = f[0];
    case (c)
      0:  return 1'b0;
      1:  return z;
      2:  return z | (n ^ v);
      3:  return n ^ v;
      4:  return cy | z;
      5:  return cy;
      6:  return n;
      7:  return v;
      8:  return 1'b1;
      9:  return !z;
      10: return !(z | (n ^ v));
      11: return !(n ^ v);
      12: return !(cy | z);
      13: return !cy;
      14: return !n;
      default: return !v;
    endcase
  endfunction

  function automatic bit reg_expect(int c, logic [DW-1:0] x);
    int s;
    s = int'($signed(x));
    case (c)
      1: return s == 0;
      2: return s <= 0;
      3: return s < 0;
      5: return s != 0;
      6: return s > 0;
      7: return s >= 0;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string tag, bit t, bit il, bit fp, bit dn);
    n_tests++;
    if (taken !== t || illegal !== il || fp_off !== fp || done !== dn) begin
      n_fail++;
      $display("FAIL %s: got done=%0b taken=%0b illegal=%0b fp=%0b expected done=%0b taken=%0b illegal=%0b fp=%0b",
               tag, done, taken, illegal, fp_off, dn, t, il, fp);
    end
  endtask

  task automatic pulse();
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: got running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 0, 0, 0, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", 0, 0, 0, 0);

    // branch mode: all selectors, codes, flag patterns (R3 R4 R5 R6)
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 16; c++) begin
        for (int f = 0; f < 16; f++) begin
          mode = 2'd0; sel = 2'(s); cond = 4'(c);
          cc32 = 4'(f); cc64 = ~4'(f);
          pulse();
          if (s[0])
            check("R6 odd selector", 0, 1, 0, 1);
          else if (c == 0 || c == 8)
            check("R3 never/always", c == 8, 0, 0, 1);
          else if (c[2:0] == 2 || c[2:0] == 3)
            check("R4 signed code", flag_expect(c, s == 2 ? ~4'(f) : 4'(f)), 0, 0, 1);
          else
            check("R5 flag code", flag_expect(c, s == 2 ? ~4'(f) : 4'(f)), 0, 0, 1);
        end
      end
    end

    // move mode: all banks (R7)
    for (int b = 0; b < 8; b++) begin
      for (int c = 0; c < 16; c++) begin
        for (int f = 0; f < 16; f++) begin
          mode = 2'd1; bank_hi = b[2]; sel = b[1:0]; cond = 4'(c);
          cc32 = 4'(f); cc64 = ~4'(f);
          pulse();
          if (b < 4)
            check("R7 fp bank", 0, 0, 1, 1);
          else if (b == 5 || b == 7)
            check("R7 illegal bank", 0, 1, 0, 1);
          else
            check("R7 flag bank", flag_expect(c, b == 6 ? ~4'(f) : 4'(f)), 0, 0, 1);
        end
      end
    end

    // register mode: every code and value (R8 R9)
    for (int c = 0; c < 8; c++) begin
      for (int x = 0; x < (1 << DW); x++) begin
        mode = 2'd2; rcond = 3'(c); rval = DW'(x);
        cc32 = 4'hF; cc64 = 4'hF; cond = 4'h8;
        pulse();
        if (c == 0 || c == 4)
          check("R9 illegal rcond", 0, 1, 0, 1);
        else
          check("R8 reg compare", reg_expect(c, DW'(x)), 0, 0, 1);
      end
    end

    // reserved mode (R9 R10)
    mode = 2'd3; cond = 4'h8; sel = 2'd0;
    pulse();
    check("R9 reserved mode", 0, 1, 0, 1);

    // hold between requests (R2)
    mode = 2'd0; sel = 2'd0; cond = 4'h8;
    pulse();
    check("R2 taken sample", 1, 0, 0, 1);
    cond = 4'h0; mode = 2'd3;
    @(negedge clk);
    check("R2 hold idle", 1, 0, 0, 0);
    repeat (3) @(negedge clk);
    check("R2 hold longer", 1, 0, 0, 0);
    pulse();
    check("R10 illegal clears taken", 0, 1, 0, 1);
    mode = 2'd1; bank_hi = 1'b0;
    pulse();
    check("R10 fp clears illegal", 0, 0, 1, 1);
    @(negedge clk);
    check("R2 done single pulse", 0, 0, 1, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule